// File: doc/BRIEF.md
# Multiplicity Coincidence Trigger Selector

This block takes twelve already shaped and discriminated channel hits, counts how many are active in a cycle, and reduces that count to a multiplicity level: none, single, double, triple, or quadruple-and-above. A programmable trigger condition asks for at least a chosen level. A separate programmable veto names one exact level that suppresses the trigger. A trigger that survives the veto while the block is enabled and not busy becomes an accepted global trigger. That trigger appears as a one-cycle accept pulse and is copied onto four fan-out outputs.

Each acceptance sets a busy latch. Software clears it explicitly once readout is done. Triggers that arrive while busy are rejected but still counted. The block keeps an accepted-event counter and a total-event counter and captures the hit pattern of every accepted event. The block is meant to sit after the per-channel pulse stretchers of a trigger crate. Software writes the selection codes, then reads the counters and the captured pattern.

The arbiter is a two-state machine. In the state ARMED, a qualified trigger takes the transition ACCEPT into HELD. In HELD, a busy-clear request takes the transition RELEASE back to ARMED. A qualified trigger seen in HELD is counted as rejected and leaves the state unchanged. In ARMED, a busy-clear request does nothing.

Top module: `trig_select_top`

## Requirements
- R1: The multiplicity level follows the number of active bits in `hits`, sampled on a clock edge. The level codes are 0 for no hits, 1 for one hit, 2 for two hits, 3 for three hits, and 4 for four or more hits.
- R2: `eoi_sel` chooses the minimum level for a trigger: 0 is single, 1 is double, 2 is triple, 3 is quadruple. A trigger event occurs only in the cycle where the condition "level ≥ selected level" goes from false to true.
- R3: `veto_sel` chooses the veto: 0 means no veto, 1 is single, 2 is double, 3 is triple, 4 is quadruple. A trigger event is discarded when the level equals the veto level exactly. Codes 5 to 7 never veto.
- R4: When `enable` is 0, no trigger is accepted and neither counter changes.
- R5: A qualified trigger in state ARMED raises `accept` for exactly one cycle, two clock edges after `hits` was sampled. All four bits of `gt_out` equal `accept`.
- R6: `busy` rises together with `accept` and stays high until a `busy_clear` request. While `busy` is high, no further trigger is accepted.
- R7: `hit_latch` takes the 12-bit hit pattern that produced the accepted trigger and holds it between acceptances.
- R8: `accepted_cnt` counts accepted triggers. `total_cnt` counts every qualified trigger while enabled, whether it is accepted or rejected for busy.
- R9: Both counters are 16 bits wide and wrap from 65535 to 0.
- R10: After reset, `accept`, `gt_out`, `busy`, `hit_latch` and both counters are 0.
- R11: `busy_clear` in state ARMED has no effect. When `busy_clear` and a qualified trigger meet in HELD, the clear wins and the trigger is counted as rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hits | input | 12 | Stretched channel hits |
| eoi_sel | input | 2 | Trigger level selection code |
| veto_sel | input | 3 | Veto level selection code |
| enable | input | 1 | Module enable, 1 = enabled |
| busy_clear | input | 1 | Request to release the busy latch |
| accept | output | 1 | One-cycle accepted trigger pulse |
| gt_out | output | 4 | Fan-out copies of the accepted trigger |
| busy | output | 1 | Busy latch |
| hit_latch | output | 12 | Hit pattern of the last accepted trigger |
| accepted_cnt | output | 16 | Accepted trigger counter |
| total_cnt | output | 16 | Total qualified trigger counter |

## Verification
The counter wrap is the situation hardest to reach from the ports. It needs 65536 qualified triggers, and each one must be an edge of the level condition. The stimulus first takes one acceptance and leaves the busy latch set. It then toggles one hit on and off every cycle pair. Every pair yields a rejected trigger, so the total counter wraps in about 131k cycles while the accepted counter and the captured pattern must stay frozen. The case where a busy clear and a trigger arrive in the same cycle also needs care: the clear is placed one cycle after the hit change, so that it lines up with the cycle in which the trigger is evaluated.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [2:0] {
        LVL_NONE  = 3'd0,
        LVL_ONE   = 3'd1,
        LVL_TWO   = 3'd2,
        LVL_THREE = 3'd3,
        LVL_FOUR  = 3'd4
    } mult_e;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_HELD  = 1'b1
    } arb_e;
endpackage

// File: rtl/mult_count.sv
module mult_count
    import trig_pkg::*;
#(
    parameter int N_HITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_HITS-1:0] hits,
    output mult_e             lvl_q,
    output logic [N_HITS-1:0] hits_q
);
    localparam int CW = $clog2(N_HITS + 1);

    logic [CW-1:0] ones;
    mult_e         lvl_d;

    always_comb begin
        ones = '0;
        for (int i = 0; i < N_HITS; i++) begin
            ones = ones + CW'(hits[i]);
        end
    end

    always_comb begin
        if (ones >= CW'(4)) lvl_d = LVL_FOUR;
        else                lvl_d = mult_e'(ones[2:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= LVL_NONE;
            hits_q <= '0;
        end else begin
            lvl_q  <= lvl_d;
            hits_q <= hits;
        end
    end
endmodule

// File: rtl/cond_select.sv
module cond_select
    import trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mult_e      lvl,
    input  logic [1:0] eoi_sel,
    input  logic [2:0] veto_sel,
    output logic       cand
);
    logic meets;
    logic meets_d;
    logic vetoed;

    always_comb begin
        meets  = (3'(lvl) >= ({1'b0, eoi_sel} + 3'd1));
        vetoed = (veto_sel != 3'd0) && (3'(lvl) == veto_sel);
        cand   = meets && !meets_d && !vetoed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) meets_d <= 1'b0;
        else        meets_d <= meets;
    end
endmodule

// File: rtl/accept_fsm.sv
module accept_fsm
    import trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cand,
    input  logic enable,
    input  logic busy_clear,
    output logic take,
    output logic reject,
    output logic accept,
    output logic busy
);
    arb_e state_q;
    arb_e state_d;
    logic qual;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            accept  <= 1'b0;
        end else begin
            state_q <= state_d;
            accept  <= take;
        end
    end

    always_comb begin
        qual    = cand && enable;
        state_d = state_q;
        take    = 1'b0;
        reject  = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (qual) begin
                    take    = 1'b1;
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                reject = qual;
                if (busy_clear) state_d = ST_ARMED;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    assign busy = (state_q == ST_HELD);
endmodule

// File: rtl/event_counters.sv
module event_counters #(
    parameter int CNT_W = 16,
    parameter int N_CNT = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CNT-1:0]       inc,
    output logic [N_CNT*CNT_W-1:0] counts
);
    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        logic [CNT_W-1:0] c_q;
        always_ff @(posedge clk) begin
            if (!rst_n)      c_q <= '0;
            else if (inc[g]) c_q <= c_q + CNT_W'(1);
        end
        assign counts[g*CNT_W +: CNT_W] = c_q;
    end
endmodule

// File: rtl/trig_select_top.sv
module trig_select_top
    import trig_pkg::*;
#(
    parameter int N_HITS = 12,
    parameter int CNT_W  = 16,
    parameter int N_GT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_HITS-1:0] hits,
    input  logic [1:0]        eoi_sel,
    input  logic [2:0]        veto_sel,
    input  logic              enable,
    input  logic              busy_clear,
    output logic              accept,
    output logic [N_GT-1:0]   gt_out,
    output logic              busy,
    output logic [N_HITS-1:0] hit_latch,
    output logic [CNT_W-1:0]  accepted_cnt,
    output logic [CNT_W-1:0]  total_cnt
);
    mult_e              lvl_q;
    logic [N_HITS-1:0]  hits_q;
    logic               cand;
    logic               take;
    logic               reject;
    logic [2*CNT_W-1:0] counts;

    mult_count #(.N_HITS(N_HITS)) u_mult (
        .clk(clk), .rst_n(rst_n), .hits(hits), .lvl_q(lvl_q), .hits_q(hits_q)
    );

    cond_select u_cond (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_q), .eoi_sel(eoi_sel),
        .veto_sel(veto_sel), .cand(cand)
    );

    accept_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cand(cand), .enable(enable),
        .busy_clear(busy_clear), .take(take), .reject(reject),
        .accept(accept), .busy(busy)
    );

    event_counters #(.CNT_W(CNT_W), .N_CNT(2)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc({take | reject, take}), .counts(counts)
    );

    assign accepted_cnt = counts[CNT_W-1:0];
    assign total_cnt    = counts[2*CNT_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n)    hit_latch <= '0;
        else if (take) hit_latch <= hits_q;
    end

    for (genvar g = 0; g < N_GT; g++) begin : g_fan
        assign gt_out[g] = accept;
    end
endmodule

// File: rtl/trig_select_chk.sv
module trig_select_chk #(
    parameter int N_HITS = 12,
    parameter int CNT_W  = 16,
    parameter int N_GT   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              busy_clear,
    input logic              accept,
    input logic [N_GT-1:0]   gt_out,
    input logic              busy,
    input logic [N_HITS-1:0] hit_latch,
    input logic [CNT_W-1:0]  accepted_cnt,
    input logic [CNT_W-1:0]  total_cnt
);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    a_r5_fanout_copy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (gt_out == {N_GT{1'b1}}));

    a_r6_busy_with_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> busy);

    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !busy_clear) |=> busy);

    a_r11_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_clear) |=> !busy);

    a_r4_disabled_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !accept);

    a_r4_disabled_counts_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(total_cnt) && $stable(accepted_cnt)));

    a_r7_pattern_held: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> $stable(hit_latch));

    a_r8_total_follows: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (total_cnt == $past(total_cnt) + CNT_W'(1)));
endmodule

bind trig_select_top trig_select_chk #(.N_HITS(N_HITS), .CNT_W(CNT_W), .N_GT(N_GT)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .busy_clear(busy_clear),
    .accept(accept), .gt_out(gt_out), .busy(busy), .hit_latch(hit_latch),
    .accepted_cnt(accepted_cnt), .total_cnt(total_cnt)
);

// File: tb/trig_select_top_test.sv
module trig_select_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] hits = '0;
    logic [1:0]  eoi_sel = 2'd0;
    logic [2:0]  veto_sel = 3'd0;
    logic        enable = 1'b1;
    logic        busy_clear = 1'b0;
    logic        accept;
    logic [3:0]  gt_out;
    logic        busy;
    logic [11:0] hit_latch;
    logic [15:0] accepted_cnt;
    logic [15:0] total_cnt;

    int ncmp = 0;
    int nbad = 0;
    int cycles = 0;
    bit running = 1'b0;
    bit ended = 1'b0;

    // reference model state
    int m_lvl = 0, m_hits = 0, m_meets_d = 0, m_busy = 0, m_accept = 0;
    int m_pat = 0, m_acc = 0, m_tot = 0;

    always #4 clk = ~clk;

    trig_select_top uut (
        .clk(clk), .rst_n(rst_n), .hits(hits), .eoi_sel(eoi_sel),
        .veto_sel(veto_sel), .enable(enable), .busy_clear(busy_clear),
        .accept(accept), .gt_out(gt_out), .busy(busy), .hit_latch(hit_latch),
        .accepted_cnt(accepted_cnt), .total_cnt(total_cnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        ncmp++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        int meets, evt, vet, cand, ones;
        cycles++;
        if (!rst_n) begin
            m_lvl = 0; m_hits = 0; m_meets_d = 0; m_busy = 0;
            m_accept = 0; m_pat = 0; m_acc = 0; m_tot = 0;
        end else begin
            meets = (m_lvl >= int'(eoi_sel) + 1) ? 1 : 0;
            evt   = (meets == 1 && m_meets_d == 0) ? 1 : 0;
            vet   = (veto_sel != 0 && m_lvl == int'(veto_sel)) ? 1 : 0;
            cand  = (evt == 1 && vet == 0 && enable) ? 1 : 0;
            m_accept = 0;
            if (m_busy == 0) begin
                if (cand == 1) begin
                    m_accept = 1; m_busy = 1; m_pat = m_hits;
                    m_acc = (m_acc + 1) % 65536;
                    m_tot = (m_tot + 1) % 65536;
                end
            end else begin
                if (busy_clear) m_busy = 0;
                if (cand == 1) m_tot = (m_tot + 1) % 65536;
            end
            m_meets_d = meets;
            ones = $countones(hits);
            m_lvl = (ones > 4) ? 4 : ones;
            m_hits = int'(hits);
        end
    end

    always @(negedge clk) begin
        if (running) begin
            check("R5 accept", int'(accept), m_accept);
            check("R5 gt_out", int'(gt_out), m_accept * 15);
            check("R6 busy", int'(busy), m_busy);
            check("R7 hit_latch", int'(hit_latch), m_pat);
            check("R8 accepted_cnt", int'(accepted_cnt), m_acc);
            check("R8 total_cnt", int'(total_cnt), m_tot);
        end
    end

    always @(posedge clk) begin
        if (cycles > 190000) begin
            nbad++;
            $display("FAIL watchdog expired actual=%0d expected<=190000", cycles);
            finish_run();
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic release_busy();
        busy_clear = 1'b1;
        step(1);
        busy_clear = 1'b0;
        step(1);
    endtask

    initial begin
        int a0, t0;
        step(3);
        rst_n = 1'b1;
        running = 1'b1;
        step(1);
        // R10 reset state
        check("R10 accept", int'(accept), 0);
        check("R10 gt_out", int'(gt_out), 0);
        check("R10 busy", int'(busy), 0);
        check("R10 hit_latch", int'(hit_latch), 0);
        check("R10 counters", int'(accepted_cnt) + int'(total_cnt), 0);

        // R1/R2: triple threshold, two hits are not enough
        eoi_sel = 2'd2;
        hits = 12'h003; step(4);
        check("R1 two hits below triple", int'(accepted_cnt), 0);
        hits = 12'h083; step(1);
        step(1);
        check("R5 accept two edges after sample", int'(accept), 1);
        check("R2 triple accepted", int'(accepted_cnt), 1);
        check("R7 pattern captured", int'(hit_latch), 'h083);
        step(2);
        hits = 12'h000; step(2);
        release_busy();

        // R1: five hits saturate at quadruple
        eoi_sel = 2'd3;
        hits = 12'h01F; step(3);
        check("R1 five hits meet quadruple", int'(accepted_cnt), 2);
        hits = 12'h000; step(2);
        release_busy();

        // R3: double vetoed, triple passes
        eoi_sel = 2'd0; veto_sel = 3'd2;
        hits = 12'h500; step(3);
        check("R3 exact-level veto", int'(accepted_cnt), 2);
        hits = 12'h000; step(2);
        hits = 12'h700; step(3);
        check("R3 other level passes", int'(accepted_cnt), 3);
        hits = 12'h000; step(2);
        release_busy();
        veto_sel = 3'd6;
        hits = 12'h001; step(3);
        check("R3 code 6 never vetoes", int'(accepted_cnt), 4);
        hits = 12'h000; step(2);
        release_busy();
        veto_sel = 3'd0;

        // R2: held level produces only one event
        hits = 12'h010; step(3);
        hits = 12'h030; step(3);
        check("R2 one event per rising edge", int'(total_cnt), 5);
        hits = 12'h000; step(2);
        release_busy();

        // R4: disabled
        enable = 1'b0;
        a0 = int'(accepted_cnt); t0 = int'(total_cnt);
        hits = 12'h002; step(3);
        hits = 12'h000; step(2);
        check("R4 disabled accepted frozen", int'(accepted_cnt), a0);
        check("R4 disabled total frozen", int'(total_cnt), t0);
        check("R4 disabled no busy", int'(busy), 0);
        enable = 1'b1;

        // R11: clear while armed has no effect
        release_busy();
        hits = 12'h800; step(3);
        check("R11 armed clear ignored", int'(accepted_cnt), a0 + 1);
        hits = 12'h000; step(2);

        // R6/R8: rejected while busy
        for (int k = 0; k < 3; k++) begin
            hits = 12'h040; step(2);
            hits = 12'h000; step(2);
        end
        check("R6 held while busy", int'(accepted_cnt), a0 + 1);
        check("R8 rejected counted", int'(total_cnt), t0 + 4);
        check("R7 pattern held", int'(hit_latch), 'h800);

        // R11: clear coincident with trigger
        hits = 12'h004; step(1);
        busy_clear = 1'b1; step(1);
        busy_clear = 1'b0;
        check("R11 clear wins", int'(busy), 0);
        check("R11 coincident rejected", int'(total_cnt), t0 + 5);
        check("R11 not accepted", int'(accepted_cnt), a0 + 1);
        hits = 12'h000; step(2);

        // R9: total wraps while busy
        hits = 12'h020; step(2);
        hits = 12'h000; step(2);
        a0 = int'(accepted_cnt); t0 = int'(total_cnt);
        for (int k = 0; k < 65536; k++) begin
            hits = 12'h001; step(1);
            hits = 12'h000; step(1);
        end
        step(2);
        check("R9 total wraps", int'(total_cnt), t0);
        check("R9 accepted frozen", int'(accepted_cnt), a0);

        step(2);
        finish_run();
    end
endmodule